// File: doc/BRIEF.md
# Sixteen-bit multicycle register-target processor core

This block is a small 16-bit processor core that takes several clock cycles per instruction. It has sixteen 16-bit general registers and a 4-bit opcode. It fetches instruction words from a memory with one synchronous port, which is addressed in bytes and holds 16-bit words. Each instruction then passes through a fixed series of phases: fetch, decode, operand read, an optional settle, memory or link phase, and execute. Every branch and jump takes its destination from a register. There are no PC-relative offsets. A 16-bit constant is built from two instructions, one that writes the high byte and one that writes the low byte.

The core has a display output, which carries a 16-bit value and a one-cycle strobe. It also has the hooks that an external interrupt unit needs: a request and acknowledge pair, a target address, a saved program counter that is valid during the acknowledge, a strobe for the mask instruction, and a strobe for the return instruction. On return the core reloads the PC from an input. Interrupt arbitration and masking policy are left to the interrupt unit.

Top module: `mc16_core`

## Requirements
- R1: While reset is asserted, and directly after it is released, the PC is 0 and every register holds 0. The core presents address 0 to memory at once. `mem_we`, `disp_strobe`, `irq_ack`, `mask_strobe` and `rfi_strobe` are all low.
- R2: Instructions are 16 bits wide, with the opcode in bits 15:12.
  - Three-register form: rd in 11:8, rs in 7:4, rt in 3:0.
  - Immediate form: rd in 11:8, imm in 7:0.
  - Jump form: bits 11:4 are zero, and the target register is in 3:0.
  - Opcodes: ADD=0, SUB=1, OR=2, SLL=3, LW=4, SW=5, BEQ=6, BNE=7, SLT=8, DISP=9, LUI=10, LLI=11, J=12, JAL=13, MASKI=14, RFI=15.
- R3: ADD, SUB and OR write rs+rt, rs-rt and rs|rt to rd, modulo 2^16. SLL writes rs shifted left by rt[3:0]. Each of these takes 4 cycles.
- R4: SLT writes 1 to rd when rs is less than rt, both taken as signed values, and writes 0 otherwise.
- R5: LUI replaces bits 15:8 of rd with imm. LLI replaces bits 7:0 of rd with imm. In both cases the other byte of rd is kept.
- R6: LW loads rd from the byte address rs+rt and takes 5 cycles. SW stores rd to the byte address rs+rt and takes 4 cycles.
- R7: BEQ and BNE compare rd with rs. When the condition holds, the PC is set to the value of rt. BEQ, BNE and SLT spend one extra settle phase, so each takes 5 cycles.
- R8: J sets the PC to the value of the target register. JAL first writes the address of the following instruction to register 15, then jumps to the value the target register held before that write.
- R9: Register 0 always reads as 0, and writes to it are ignored.
- R10: The PC advances by 2 for each instruction fetched.
- R11: DISP drives the value of rs on `disp_data`, with `disp_strobe` high for exactly one cycle.
- R12: At an instruction boundary, a high `irq_req` makes the core spend one cycle with `irq_ack` high. During that cycle `saved_pc` holds the address of the next instruction the program would run. This is the branch target when the previous instruction branched. Fetching then continues at `irq_target`.
- R13: MASKI pulses `mask_strobe` for one cycle. RFI pulses `rfi_strobe` for one cycle and continues fetching at `ret_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Byte address of the memory access |
| mem_we | output | 1 | Store strobe |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, one cycle after its address |
| disp_data | output | 16 | Display value |
| disp_strobe | output | 1 | Display value valid, one cycle |
| irq_req | input | 1 | Interrupt request from the interrupt unit |
| irq_target | input | 16 | Handler start address |
| irq_ack | output | 1 | Request taken, one cycle |
| saved_pc | output | 16 | Resume address, valid with irq_ack |
| mask_strobe | output | 1 | Mask instruction executed |
| rfi_strobe | output | 1 | Return instruction executed |
| ret_pc | input | 16 | Resume address used by the return instruction |

## Verification
A taken branch and an interrupt can land on the same instruction boundary. The branch result is written to the PC at the end of the execute phase, and the very next fetch phase samples the request. The bench raises `irq_req` while a taken BEQ is still in its operand phase. It then judges the result in three ways: `saved_pc` at the acknowledge must equal the branch target, the two display instructions between the branch and its target must never strobe, and execution must resume at the target after RFI. A GCD program run over a table of operand pairs covers the compare, subtract, swap and link paths together.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  localparam int WORD_W = 16;
  localparam int SEL_W  = 4;
  localparam int IMM_W  = 8;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_SUB   = 4'h1,
    OP_OR    = 4'h2,
    OP_SLL   = 4'h3,
    OP_LW    = 4'h4,
    OP_SW    = 4'h5,
    OP_BEQ   = 4'h6,
    OP_BNE   = 4'h7,
    OP_SLT   = 4'h8,
    OP_DISP  = 4'h9,
    OP_LUI   = 4'hA,
    OP_LLI   = 4'hB,
    OP_J     = 4'hC,
    OP_JAL   = 4'hD,
    OP_MASKI = 4'hE,
    OP_RFI   = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_READ,
    ST_SETTLE,
    ST_EXEC,
    ST_MEMRD,
    ST_LINK,
    ST_INTR
  } phase_e;

  typedef struct packed {
    opcode_e            op;
    logic [SEL_W-1:0]   rd;
    logic [SEL_W-1:0]   rs;
    logic [SEL_W-1:0]   rt;
  } instr_t;

  // Result of the three-register arithmetic group; also forms addresses.
  function automatic logic [WORD_W-1:0] alu_result(opcode_e op,
                                                   logic [WORD_W-1:0] s,
                                                   logic [WORD_W-1:0] t);
    logic [WORD_W-1:0] r;
    case (op)
      OP_SUB:  r = s - t;
      OP_OR:   r = s | t;
      OP_SLL:  r = s << t[SEL_W-1:0];
      default: r = s + t;
    endcase
    return r;
  endfunction

  function automatic logic signed_less(logic [WORD_W-1:0] a, logic [WORD_W-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  // Replace one byte of a register, keeping the other one.
  function automatic logic [WORD_W-1:0] byte_merge(logic upper,
                                                   logic [WORD_W-1:0] old,
                                                   logic [IMM_W-1:0] imm);
    return upper ? {imm, old[IMM_W-1:0]} : {old[WORD_W-1:IMM_W], imm};
  endfunction

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int W = 16,
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_d,
  input  logic [AW-1:0] ra_s,
  input  logic [AW-1:0] ra_t,
  output logic [W-1:0]  rd_d,
  output logic [W-1:0]  rd_s,
  output logic [W-1:0]  rd_t
);

  logic [N-1:0][W-1:0] regs;

  generate
    for (genvar i = 0; i < N; i++) begin : g_reg
      if (i == 0) begin : g_zero
        assign regs[i] = '0;
      end else begin : g_store
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                          q <= '0;
          else if (we && waddr == AW'(i))      q <= wdata;
        end
        assign regs[i] = q;
      end
    end
  endgenerate

  assign rd_d = regs[ra_d];
  assign rd_s = regs[ra_s];
  assign rd_t = regs[ra_t];

  // R3: a write to a nonzero register is visible on the next cycle
  assert_wb_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e op,
  input  logic    irq_req,
  output phase_e  phase
);

  phase_e nxt;

  always_comb begin
    nxt = phase;
    case (phase)
      ST_FETCH:  nxt = irq_req ? ST_INTR : ST_DECODE;
      ST_INTR:   nxt = ST_FETCH;
      ST_DECODE: nxt = ST_READ;
      ST_READ: begin
        case (op)
          OP_BEQ, OP_BNE, OP_SLT: nxt = ST_SETTLE;
          OP_JAL:                 nxt = ST_LINK;
          OP_LW:                  nxt = ST_MEMRD;
          default:                nxt = ST_EXEC;
        endcase
      end
      ST_SETTLE, ST_LINK, ST_MEMRD: nxt = ST_EXEC;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= ST_FETCH;
    else        phase <= nxt;
  end

  // R7: compare-type execution always follows a settle phase
  assert_settle_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_EXEC && (op == OP_BEQ || op == OP_BNE || op == OP_SLT))
      |-> $past(phase) == ST_SETTLE);

  // R12: an interrupt is only taken at a boundary with a pending request
  assert_irq_boundary_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_INTR) |-> ($past(phase) == ST_FETCH && $past(irq_req)));

endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int               NREG     = 16,
  parameter logic [WORD_W-1:0] RESET_PC = '0,
  localparam int              RAW      = $clog2(NREG),
  localparam logic [WORD_W-1:0] PC_STEP = WORD_W'(WORD_W / 8),
  localparam logic [RAW-1:0]  LINK_REG = RAW'(NREG - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] disp_data,
  output logic              disp_strobe,
  input  logic              irq_req,
  input  logic [WORD_W-1:0] irq_target,
  output logic              irq_ack,
  output logic [WORD_W-1:0] saved_pc,
  output logic              mask_strobe,
  output logic              rfi_strobe,
  input  logic [WORD_W-1:0] ret_pc
);

  phase_e            phase;
  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q;
  instr_t            ir;
  logic [WORD_W-1:0] opd_q, ops_q, opt_q;
  logic              flag_q;
  logic              cond_hit;

  logic              rf_we;
  logic [RAW-1:0]    rf_waddr;
  logic [WORD_W-1:0] rf_wdata;
  logic [WORD_W-1:0] rf_d, rf_s, rf_t;

  // Named internal events, used by the datapath and by the assertions.
  logic              ev_exec;
  logic              ev_branch_taken;
  logic              ev_jump;
  logic              ev_link;
  logic              ev_rfi;
  logic              ev_redirect;
  logic              ev_mem_phase;
  logic [WORD_W-1:0] eff_addr;
  logic [IMM_W-1:0]  imm;

  assign ir  = instr_t'(ir_q);
  assign imm = {ir.rs, ir.rt};

  mc16_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (ir.op),
    .irq_req (irq_req),
    .phase   (phase)
  );

  mc16_regfile #(.W(WORD_W), .N(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra_d  (ir.rd),
    .ra_s  (ir.rs),
    .ra_t  (ir.rt),
    .rd_d  (rf_d),
    .rd_s  (rf_s),
    .rd_t  (rf_t)
  );

  always_comb begin
    case (ir.op)
      OP_BEQ:  cond_hit = (opd_q == ops_q);
      OP_BNE:  cond_hit = (opd_q != ops_q);
      default: cond_hit = signed_less(ops_q, opt_q);
    endcase
  end

  assign ev_exec         = (phase == ST_EXEC);
  assign ev_branch_taken = ev_exec && (ir.op == OP_BEQ || ir.op == OP_BNE) && flag_q;
  assign ev_jump         = ev_exec && (ir.op == OP_J || ir.op == OP_JAL);
  assign ev_rfi          = ev_exec && (ir.op == OP_RFI);
  assign ev_link         = (phase == ST_LINK);
  assign ev_redirect     = ev_branch_taken || ev_jump || ev_rfi;
  assign eff_addr        = alu_result(OP_ADD, ops_q, opt_q);
  assign ev_mem_phase    = (phase == ST_MEMRD) || (ev_exec && ir.op == OP_SW);

  // Register write-back selection
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = ir.rd;
    rf_wdata = alu_result(ir.op, ops_q, opt_q);
    if (ev_link) begin
      rf_we    = 1'b1;
      rf_waddr = LINK_REG;
      rf_wdata = pc_q;
    end else if (ev_exec) begin
      case (ir.op)
        OP_ADD, OP_SUB, OP_OR, OP_SLL: rf_we = 1'b1;
        OP_SLT: begin
          rf_we    = 1'b1;
          rf_wdata = {{(WORD_W-1){1'b0}}, flag_q};
        end
        OP_LUI, OP_LLI: begin
          rf_we    = 1'b1;
          rf_wdata = byte_merge(ir.op == OP_LUI, opd_q, imm);
        end
        OP_LW: begin
          rf_we    = 1'b1;
          rf_wdata = mem_rdata;
        end
        default: rf_we = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      ir_q   <= '0;
      opd_q  <= '0;
      ops_q  <= '0;
      opt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      case (phase)
        ST_DECODE: begin
          ir_q <= mem_rdata;
          pc_q <= pc_q + PC_STEP;
        end
        ST_READ: begin
          opd_q <= rf_d;
          ops_q <= rf_s;
          opt_q <= rf_t;
        end
        ST_SETTLE: flag_q <= cond_hit;
        ST_INTR:   pc_q   <= irq_target;
        ST_EXEC: begin
          if (ev_redirect) pc_q <= ev_rfi ? ret_pc : opt_q;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr    = ev_mem_phase ? eff_addr : pc_q;
  assign mem_we      = ev_exec && (ir.op == OP_SW);
  assign mem_wdata   = opd_q;
  assign disp_data   = ops_q;
  assign disp_strobe = ev_exec && (ir.op == OP_DISP);
  assign irq_ack     = (phase == ST_INTR);
  assign saved_pc    = pc_q;
  assign mask_strobe = ev_exec && (ir.op == OP_MASKI);
  assign rfi_strobe  = ev_rfi;

  // R10: operand phase always sees the PC two bytes past the fetched word
  assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_READ) |-> pc_q == $past(pc_q) + PC_STEP);

  // R8: the link write happens the cycle before the jump and carries the PC
  assert_link_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_exec && ir.op == OP_JAL)
      |-> ($past(rf_we) && $past(rf_waddr) == LINK_REG && $past(rf_wdata) == pc_q));

  // R12: acknowledge lasts one cycle and vectors the PC to the handler
  assert_irq_vector_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (pc_q == $past(irq_target) && !irq_ack));

  // R11: display strobe is a single-cycle pulse
  assert_disp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    disp_strobe |=> !disp_strobe);

  // R9: displaying register zero always shows zero
  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_strobe && ir.rs == '0) |-> disp_data == '0);

  // R6: a store only issues straight after its operand phase
  assert_store_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(phase) == ST_READ);

endmodule

// File: tb/mc16_core_bench.sv
`timescale 1ns/1ps
module mc16_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, disp_data, saved_pc;
  logic        mem_we, disp_strobe, irq_ack, mask_strobe, rfi_strobe;
  logic        irq_req = 1'b0;
  logic [15:0] irq_target = 16'h0060;
  logic [15:0] ret_pc = 16'h0000;

  always #2.5 clk = ~clk;

  mc16_core u_mc16_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .disp_data(disp_data),
    .disp_strobe(disp_strobe), .irq_req(irq_req), .irq_target(irq_target),
    .irq_ack(irq_ack), .saved_pc(saved_pc), .mask_strobe(mask_strobe),
    .rfi_strobe(rfi_strobe), .ret_pc(ret_pc)
  );

  // Word memory, byte addressed, one-cycle read latency
  logic [15:0] mem [0:127];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:1]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:1]];
  end

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: display log, strobe counts, interrupt unit model
  logic [15:0] disp_log [0:63];
  int          disp_cyc [0:63];
  int          disp_cnt = 0;
  int          cyc = 0;
  int          ack_cnt = 0, mask_cnt = 0, rfi_cnt = 0;
  logic [15:0] saved_cap = 16'h0;
  bit          irq_arm = 0;
  bit          irq_seen = 0;

  always @(negedge clk) begin
    cyc++;
    if (disp_strobe && disp_cnt < 64) begin
      disp_log[disp_cnt] = disp_data;
      disp_cyc[disp_cnt] = cyc;
      disp_cnt++;
    end
    if (mask_strobe) mask_cnt++;
    if (rfi_strobe)  rfi_cnt++;
    if (irq_ack) begin
      ack_cnt++;
      saved_cap = saved_pc;
      ret_pc    = saved_pc;
      irq_req   = 1'b0;
      irq_seen  = 1;
    end else if (irq_arm && !irq_seen && !irq_req && mem_addr == 16'd46) begin
      irq_req = 1'b1;
    end
  end

  function automatic logic [15:0] ia(int op, int rd, int rs, int rt);
    return {op[3:0], rd[3:0], rs[3:0], rt[3:0]};
  endfunction
  function automatic logic [15:0] il(int op, int rd, int imm);
    return {op[3:0], rd[3:0], imm[7:0]};
  endfunction
  function automatic logic [15:0] ij(int op, int rt);
    return {op[3:0], 8'h00, rt[3:0]};
  endfunction

  task automatic put(int baddr, logic [15:0] w);
    mem[baddr / 2] = w;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_disps(int target, int limit);
    int k = 0;
    while (disp_cnt < target && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  // GCD by repeated subtraction, then a JAL whose link value is displayed
  task automatic load_gcd(logic [15:0] a, logic [15:0] b);
    clear_mem();
    put(0,  il(11, 4, 8'h80));
    put(2,  ia(4, 1, 4, 0));
    put(4,  il(11, 5, 2));
    put(6,  ia(4, 2, 4, 5));
    put(8,  il(11, 9, 14));
    put(10, il(11, 6, 32));
    put(12, il(11, 8, 24));
    put(14, ia(6, 2, 0, 6));
    put(16, ia(8, 7, 1, 2));
    put(18, ia(7, 7, 0, 8));
    put(20, ia(1, 1, 1, 2));
    put(22, ij(12, 9));
    put(24, ia(0, 10, 1, 0));
    put(26, ia(0, 1, 2, 0));
    put(28, ia(0, 2, 10, 0));
    put(30, ij(12, 9));
    put(32, ia(9, 0, 1, 0));
    put(34, il(11, 11, 40));
    put(36, ij(13, 11));
    put(38, ia(9, 0, 1, 0));
    put(40, ia(9, 0, 15, 0));
    put(42, il(11, 12, 44));
    put(44, ij(12, 12));
    put(16'h80, a);
    put(16'h82, b);
  endtask

  task automatic load_mixed();
    clear_mem();
    put(0,  il(10, 1, 8'h12));
    put(2,  il(11, 1, 8'h34));
    put(4,  ia(9, 0, 1, 0));
    put(6,  il(11, 2, 4));
    put(8,  ia(3, 3, 1, 2));
    put(10, ia(9, 0, 3, 0));
    put(12, il(11, 4, 8'h0F));
    put(14, ia(2, 5, 3, 4));
    put(16, ia(9, 0, 5, 0));
    put(18, il(11, 6, 8'h90));
    put(20, ia(5, 5, 6, 0));
    put(22, ia(4, 7, 0, 6));
    put(24, ia(9, 0, 7, 0));
    put(26, ia(0, 0, 5, 5));
    put(28, ia(9, 0, 0, 0));
    put(30, il(11, 8, 8'hFF));
    put(32, il(10, 8, 8'h80));
    put(34, ia(8, 9, 8, 1));
    put(36, ia(9, 0, 9, 0));
    put(38, ia(8, 9, 1, 8));
    put(40, ia(9, 0, 9, 0));
    put(42, il(11, 10, 50));
    put(44, ia(6, 0, 0, 10));
    put(46, ia(9, 0, 1, 0));
    put(48, ia(9, 0, 1, 0));
    put(50, ij(14, 0));
    put(52, ia(9, 0, 4, 0));
    put(54, il(11, 11, 56));
    put(56, ij(12, 11));
    put(96, ia(9, 0, 10, 0));
    put(98, ij(15, 0));
  endtask

  // {a, b, gcd(a,b)}
  localparam logic [47:0] GCD_VEC [0:7] = '{
    {16'd48,   16'd18,  16'd6},
    {16'd17,   16'd5,   16'd1},
    {16'd100,  16'd100, 16'd100},
    {16'd0,    16'd5,   16'd5},
    {16'd7,    16'd0,   16'd7},
    {16'd1071, 16'd462, 16'd21},
    {16'd255,  16'd1,   16'd1},
    {16'd36,   16'd84,  16'd12}
  };

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int base;
    load_gcd(16'd1, 16'd1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: idle outputs and address 0 while in reset
    chk("R1 reset addr", mem_addr, 16'h0000);
    chk("R1 reset we", {15'b0, mem_we}, 16'h0);
    chk("R1 reset strobes", {13'b0, disp_strobe, irq_ack, mask_strobe | rfi_strobe}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first fetch addr", mem_addr, 16'h0000);

    // Table walk: GCD program (R2 R3 R4 R6 R7 R8 R10)
    for (int v = 0; v < 8; v++) begin
      load_gcd(GCD_VEC[v][47:32], GCD_VEC[v][31:16]);
      do_reset();
      base = disp_cnt;
      wait_disps(base + 2, 20000);
      chk($sformatf("R2/R3/R4/R7 gcd vector %0d", v), disp_log[base], GCD_VEC[v][15:0]);
      chk($sformatf("R8/R10 link value vector %0d", v), disp_log[base + 1], 16'd38);
    end

    // Directed: byte loads, shift, or, memory, zero reg, signed compare,
    // branch coinciding with interrupt, mask and return
    load_mixed();
    do_reset();
    base = disp_cnt;
    irq_arm = 1;
    wait_disps(base + 9, 3000);
    repeat (100) @(negedge clk);
    irq_arm = 0;
    chk("R5 lui/lli", disp_log[base], 16'h1234);
    chk("R3 sll", disp_log[base + 1], 16'h1234 << 4);
    chk("R3 or", disp_log[base + 2], (16'h1234 << 4) | 16'h000F);
    chk("R6 load back", disp_log[base + 3], 16'h234F);
    chk("R6 memory word", mem[16'h90 / 2], 16'h234F);
    chk("R9 zero reg", disp_log[base + 4], 16'h0000);
    chk("R4 neg lt pos", disp_log[base + 5], 16'h0001);
    chk("R4 pos lt neg", disp_log[base + 6], 16'h0000);
    chk("R12 handler ran", disp_log[base + 7], 16'd50);
    chk("R13 resumed", disp_log[base + 8], 16'h000F);
    chk("R11/R7 disp count", 16'(disp_cnt - base), 16'd9);
    chk("R12 saved pc is target", saved_cap, 16'd50);
    chk("R12 ack count", 16'(ack_cnt), 16'd1);
    chk("R13 mask strobe", 16'(mask_cnt), 16'd1);
    chk("R13 rfi strobe", 16'(rfi_cnt), 16'd1);
    chk("R7 compare cycles", 16'(disp_cyc[base + 6] - disp_cyc[base + 5]), 16'd9);
    chk("R6 store/load cycles", 16'(disp_cyc[base + 3] - disp_cyc[base + 2]), 16'd17);
    chk("R3 alu cycles", 16'(disp_cyc[base + 1] - disp_cyc[base]), 16'd12);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule